// File: doc/BRIEF.md
# Rate-1/3 Turbo Block Encoder

This block turns one information block into a turbo codeword. Two identical recursive systematic convolutional encoders with eight states run over the block. The first encoder takes the bits in their natural order. The second takes them in a permuted order, which an on-the-fly address generator produces. Two block lengths are supported, 512 and 2048 bits, and each has its own permutation. The whole block is first captured in an internal bit buffer. The second encoder can then fetch any position while the first fetches position i, both in the same cycle.

Bits arrive one per beat on a valid/ready stream. The first beat of a block carries a start marker and the length select. A block may be closed early with a last marker, and the block then fills the unused positions with zeros. The output stream has one beat per information position, each beat holding a systematic bit and two parity bits, in index order. Six termination beats follow them and bring both encoders back to the all-zero state. A new block is taken only once the previous block's final termination beat has left the block.

The controller is a five-state machine:
- IDLE waits for a start beat. IDLE→LOAD on a start beat without the last marker; IDLE→PAD on a start beat that carries the last marker.
- LOAD stores beats. LOAD→PAD on an early last marker; LOAD→DATA when the final position has been written.
- PAD writes zeros. PAD→DATA once the final position has been zeroed.
- DATA emits the coded beats. DATA→TAIL after the final coded beat is accepted.
- TAIL emits the termination beats. TAIL→IDLE after the sixth termination beat is accepted.

Top module: `turbo_pccc_enc`

## Requirements
- R1: Out of reset, out_valid is 0 and in_ready is 1.
- R2: In IDLE, in_ready is 1. A beat without in_start is consumed and discarded. A beat with in_start becomes information bit 0. in_size is sampled on that beat: 1 selects K=2048 and 0 selects K=512.
- R3: out_par0 for position i comes from an encoder over the natural-order bits, starting from the zero state. With the register taps d1, d2, d3 (d1 the newest), w = u ^ d2 ^ d3, parity = w ^ d1 ^ d3, and the taps then shift to (w, d1, d2). This gives feedback 1+D^2+D^3 and parity 1+D+D^3.
- R4: out_par1 for position i comes from an identical encoder fed with bit pi(i) = (f1*i + f2*i*i) mod K. The pair (f1, f2) is (31, 64) for K=512 and (45, 128) for K=2048.
- R5: The first K output beats carry positions 0 to K-1 in order. On each of them out_sys is the information bit and out_tail is 0.
- R6: Six termination beats follow, with out_tail set to 1. In beats 0 to 2 the natural encoder is driven with u = d2 ^ d3: out_sys = u, out_par0 = its parity, out_par1 = 0. In beats 3 to 5 the permuted encoder does the same: out_sys = u, out_par0 = 0, out_par1 = its parity. out_last is 1 only on beat 5.
- R7: If in_last is accepted at position n < K-1, positions n+1 to K-1 are encoded as 0. in_ready stays 0 while they are filled.
- R8: While out_valid is 1 and out_ready is 0, the output beat is held unchanged on the next cycle.
- R9: in_ready is 0 from the acceptance of a block's final input beat until its last termination beat is accepted. A start beat offered during this time is not taken.
- R10: Loading ends at the K-th bit even when in_last is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_bit | input | 1 | Information bit |
| in_start | input | 1 | Marks the first bit of a block |
| in_last | input | 1 | Marks the final supplied bit (early close) |
| in_size | input | 1 | Length select on a start beat: 1 = 2048, 0 = 512 |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Output beat taken |
| out_sys | output | 1 | Systematic or termination input bit |
| out_par0 | output | 1 | Parity of the natural-order encoder |
| out_par1 | output | 1 | Parity of the permuted-order encoder |
| out_tail | output | 1 | Beat is a termination beat |
| out_last | output | 1 | Final beat of the codeword |

## Verification
The bench sends random, all-ones and single-impulse blocks at both lengths and compares every output beat against a behavioural model. An impulse block puts the permutation in plain view: a wrong (f1, f2) pair or a wrong modulus moves the parity-1 response to other positions. A block closed early shows whether the pad positions are really zeroed; a design that skipped padding would encode stale buffer contents. Random output stalls and start beats offered while the block is busy would catch a design that drops or advances a held beat, or one that takes a new block in the middle of its tail. The termination beats are checked bit by bit, so feeding back the wrong tap, or emitting the two tails in the wrong order, fails at once.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PAD,
        ST_DATA,
        ST_TAIL
    } tcx_state_e;

    localparam int TERM_STEPS = 3;
    localparam int TAIL_BEATS = 2 * TERM_STEPS;
endpackage

// File: rtl/tcx_rsc.sv
module tcx_rsc (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic term,
    input  logic u_in,
    output logic sys_out,
    output logic par_out,
    output logic is_zero
);
    logic [2:0] taps;
    logic       u_eff;
    logic       fb;

    always_comb begin
        u_eff   = term ? (taps[1] ^ taps[2]) : u_in;
        fb      = u_eff ^ taps[1] ^ taps[2];
        par_out = fb ^ taps[0] ^ taps[2];
        sys_out = u_eff;
        is_zero = (taps == 3'b000);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            taps <= '0;
        else if (clear)
            taps <= '0;
        else if (step)
            taps <= {taps[1:0], fb};
    end
endmodule

// File: rtl/tcx_perm.sv
module tcx_perm #(
    parameter int LOG_KL = 11,
    parameter int LOG_KS = 9,
    parameter int F1_L   = 45,
    parameter int F2_L   = 128,
    parameter int F1_S   = 31,
    parameter int F2_S   = 64
) (
    input  logic [LOG_KL-1:0] idx,
    input  logic              long_sel,
    output logic [LOG_KL-1:0] addr
);
    localparam int SQW = 2 * LOG_KL;

    logic [SQW-1:0]    sq;
    logic [LOG_KL-1:0] sum_l;
    logic [LOG_KL-1:0] sum_s;

    always_comb begin
        sq    = {{LOG_KL{1'b0}}, idx} * {{LOG_KL{1'b0}}, idx};
        sum_l = LOG_KL'(F1_L * idx) + LOG_KL'(F2_L * sq);
        sum_s = LOG_KL'(F1_S * idx) + LOG_KL'(F2_S * sq);
        if (long_sel)
            addr = sum_l;
        else
            addr = {{(LOG_KL-LOG_KS){1'b0}}, sum_s[LOG_KS-1:0]};
    end
endmodule

// File: rtl/tcx_bitbuf.sv
module tcx_bitbuf #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rdata_a,
    output logic          rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/turbo_pccc_enc.sv
module turbo_pccc_enc #(
    parameter int LOG_K_LONG  = 11,
    parameter int LOG_K_SHORT = 9,
    parameter int F1_LONG     = 45,
    parameter int F2_LONG     = 128,
    parameter int F1_SHORT    = 31,
    parameter int F2_SHORT    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_start,
    input  logic in_last,
    input  logic in_size,
    output logic out_valid,
    input  logic out_ready,
    output logic out_sys,
    output logic out_par0,
    output logic out_par1,
    output logic out_tail,
    output logic out_last
);
    import tcx_pkg::*;

    localparam int AW = LOG_K_LONG;
    localparam logic [AW-1:0] KMAX_L = AW'((1 << LOG_K_LONG) - 1);
    localparam logic [AW-1:0] KMAX_S = AW'((1 << LOG_K_SHORT) - 1);
    localparam int TW = $clog2(TAIL_BEATS);
    localparam logic [TW-1:0] TLAST = TW'(TAIL_BEATS - 1);
    localparam logic [TW-1:0] TSPLIT = TW'(TERM_STEPS);

    tcx_state_e state, nxt;
    logic [AW-1:0] idx;
    logic [TW-1:0] tcnt;
    logic          long_q;
    logic [AW-1:0] kmax;
    logic          acc, fire, at_end;
    logic          we, wdata;
    logic [AW-1:0] perm_addr;
    logic          bit_nat, bit_perm;
    logic          sys0, par0, zero0, sys1, par1, zero1;
    logic          step0, step1, term_on;

    assign kmax    = long_q ? KMAX_L : KMAX_S;
    assign at_end  = (idx == kmax);
    assign acc     = in_valid && in_ready;
    assign fire    = out_valid && out_ready;
    assign term_on = (state == ST_TAIL);
    assign step0   = fire && ((state == ST_DATA) || (term_on && tcnt < TSPLIT));
    assign step1   = fire && ((state == ST_DATA) || (term_on && tcnt >= TSPLIT));

    tcx_bitbuf #(.AW(AW)) u_buf (
        .clk(clk), .we(we), .waddr(idx), .wdata(wdata),
        .raddr_a(idx), .raddr_b(perm_addr),
        .rdata_a(bit_nat), .rdata_b(bit_perm)
    );

    tcx_perm #(
        .LOG_KL(LOG_K_LONG), .LOG_KS(LOG_K_SHORT),
        .F1_L(F1_LONG), .F2_L(F2_LONG), .F1_S(F1_SHORT), .F2_S(F2_SHORT)
    ) u_perm (
        .idx(idx), .long_sel(long_q), .addr(perm_addr)
    );

    tcx_rsc u_enc_nat (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE), .step(step0),
        .term(term_on), .u_in(bit_nat),
        .sys_out(sys0), .par_out(par0), .is_zero(zero0)
    );

    tcx_rsc u_enc_perm (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE), .step(step1),
        .term(term_on), .u_in(bit_perm),
        .sys_out(sys1), .par_out(par1), .is_zero(zero1)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (acc && in_start) nxt = in_last ? ST_PAD : ST_LOAD;
            ST_LOAD: if (acc) begin
                if (at_end)       nxt = ST_DATA;
                else if (in_last) nxt = ST_PAD;
            end
            ST_PAD:  if (at_end) nxt = ST_DATA;
            ST_DATA: if (fire && at_end) nxt = ST_TAIL;
            ST_TAIL: if (fire && tcnt == TLAST) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            tcnt   <= '0;
            long_q <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: if (acc && in_start) begin
                    long_q <= in_size;
                    idx    <= AW'(1);
                end
                ST_LOAD: if (acc) idx <= at_end ? '0 : idx + AW'(1);
                ST_PAD:  idx <= at_end ? '0 : idx + AW'(1);
                ST_DATA: if (fire) begin
                    idx  <= at_end ? '0 : idx + AW'(1);
                    tcnt <= '0;
                end
                ST_TAIL: if (fire) tcnt <= (tcnt == TLAST) ? '0 : tcnt + TW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sys   = 1'b0;
        out_par0  = 1'b0;
        out_par1  = 1'b0;
        out_tail  = 1'b0;
        out_last  = 1'b0;
        we        = 1'b0;
        wdata     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                we       = in_valid && in_start;
                wdata    = in_bit;
            end
            ST_LOAD: begin
                in_ready = 1'b1;
                we       = in_valid;
                wdata    = in_bit;
            end
            ST_PAD: we = 1'b1;
            ST_DATA: begin
                out_valid = 1'b1;
                out_sys   = bit_nat;
                out_par0  = par0;
                out_par1  = par1;
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_tail  = 1'b1;
                out_last  = (tcnt == TLAST);
                if (tcnt < TSPLIT) begin
                    out_sys  = sys0;
                    out_par0 = par0;
                end else begin
                    out_sys  = sys1;
                    out_par1 = par1;
                end
            end
            default: ;
        endcase
    end

    // R8: a stalled beat is held
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid &&
            $stable({out_sys, out_par0, out_par1, out_tail, out_last})));

    // R3: both encoders start a codeword from the zero state
    a_r3_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (zero0 && zero1));

    // R6: termination returns both encoders to zero
    a_r6_terminated: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> (zero0 && zero1));

    // R5: the tail comes straight after an accepted data beat
    a_r5_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_tail) |-> $past(fire && !out_tail));

    // R9: no buffer write while a codeword is being emitted
    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !we);
endmodule

// File: tb/turbo_pccc_enc_bench.sv
module turbo_pccc_enc_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_start = 1'b0, in_last = 1'b0, in_size = 1'b0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_sys, out_par0, out_par1, out_tail, out_last;

    always #2 clk = ~clk;

    turbo_pccc_enc u_turbo_pccc_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .in_start(in_start), .in_last(in_last), .in_size(in_size),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sys(out_sys), .out_par0(out_par0), .out_par1(out_par1),
        .out_tail(out_tail), .out_last(out_last)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [4:0] expq[$];
    string      tagq[$];
    bit         blk[2048];
    bit         stall_en = 1'b0;
    bit         run_mon = 1'b0;
    bit         finished = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] rstep(logic [2:0] d, logic u);
        logic w, p;
        w = u ^ d[1] ^ d[2];
        p = w ^ d[0] ^ d[2];
        return {p, d[1], d[0], w};
    endfunction

    // model of R3..R6
    task automatic build_expect(bit lng);
        int k, f1, f2;
        logic [2:0] a, b;
        logic [3:0] r;
        logic pa, pb, u, v;
        k  = lng ? 2048 : 512;
        f1 = lng ? 45 : 31;
        f2 = lng ? 128 : 64;
        a = '0;
        b = '0;
        for (int i = 0; i < k; i++) begin
            longint pi_i;
            pi_i = (longint'(f1) * i + longint'(f2) * i * i) % k;
            u = blk[i];
            v = blk[int'(pi_i)];
            r = rstep(a, u); pa = r[3]; a = r[2:0];
            r = rstep(b, v); pb = r[3]; b = r[2:0];
            expq.push_back({u, pa, pb, 1'b0, 1'b0});
            tagq.push_back("R3/R4/R5 data beat");
        end
        for (int j = 0; j < 3; j++) begin
            u = a[1] ^ a[2];
            r = rstep(a, u); pa = r[3]; a = r[2:0];
            expq.push_back({u, pa, 1'b0, 1'b1, 1'b0});
            tagq.push_back("R6 tail natural");
        end
        for (int j = 0; j < 3; j++) begin
            v = b[1] ^ b[2];
            r = rstep(b, v); pb = r[3]; b = r[2:0];
            expq.push_back({v, 1'b0, pb, 1'b1, j == 2});
            tagq.push_back("R6 tail permuted");
        end
    endtask

    task automatic put(bit b, bit st, bit ls, bit sz, output bit took);
        @(negedge clk);
        in_valid = 1'b1; in_bit = b; in_start = st; in_last = ls; in_size = sz;
        #1;
        took = in_ready;
        @(posedge clk);
    endtask

    // mode: 0 random, 1 all ones, 2 single one at position 5
    task automatic send_block(bit lng, int nbits, bit mark_last, int mode, bit gaps);
        bit took, b;
        foreach (blk[i]) blk[i] = 1'b0;
        for (int n = 0; n < nbits; n++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk);
            end
            case (mode)
                0: b = 1'($urandom);
                1: b = 1'b1;
                default: b = (n == 5);
            endcase
            took = 1'b0;
            while (!took) put(b, n == 0, mark_last && (n == nbits - 1), lng, took);
            blk[n] = b;
        end
        build_expect(lng);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    endtask

    // output monitor, every clock
    always @(negedge clk) begin
        if (run_mon) begin
            out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
            if (expq.size() != 0) check("R9 in_ready low while busy", 32'(in_ready), 32'd0);
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check("R9 spurious output beat", 32'(out_valid), 32'd0);
                end else begin
                    check(stall_en ? {"R8 ", tagq[0]} : tagq[0],
                          32'({out_sys, out_par0, out_par1, out_tail, out_last}), 32'(expq[0]));
                    if (out_ready) begin
                        void'(expq.pop_front());
                        void'(tagq.pop_front());
                    end
                end
            end
        end
    end

    task automatic drain;
        while (expq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, %0d beats outstanding", expq.size());
        finish_run();
    end

    initial begin
        bit took;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);
        run_mon = 1'b1;

        // R2: beats without a start marker are discarded in idle
        for (int s = 0; s < 4; s++) begin
            put(1'b1, 1'b0, 1'b0, 1'b0, took);
            check("R2 stray beat consumed in idle", 32'(took), 32'd1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 still idle after stray beats", 32'(out_valid), 32'd0);

        // R3/R4: short block, impulse, exposes the permutation
        send_block(1'b0, 512, 1'b1, 2, 1'b0);
        drain();
        // R5/R6: short block, random with gaps
        send_block(1'b0, 512, 1'b1, 0, 1'b1);
        // R9: next start offered at once, must wait for the tail
        send_block(1'b0, 512, 1'b1, 1, 1'b0);
        drain();
        // R8: stalls on the output
        stall_en = 1'b1;
        send_block(1'b0, 512, 1'b0, 0, 1'b0);
        drain();
        // R7: early close, rest padded with zeros
        send_block(1'b0, 100, 1'b1, 1, 1'b0);
        drain();
        stall_en = 1'b0;
        // R10 and R4 long: full 2048 without in_last
        send_block(1'b1, 2048, 1'b0, 0, 1'b0);
        drain();
        // R4 long impulse and R7 on a long block
        send_block(1'b1, 700, 1'b1, 2, 1'b0);
        drain();
        @(negedge clk);
        check("R9 ready again once tail leaves", 32'(in_ready), 32'd1);
        finish_run();
    end
endmodule